// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog peripheral on a plain 32-bit register bus (address, write strobe, write data, combinational read data). A programmable prescaler divides the input clock into ticks; with the divisor set to the input clock rate divided by 1000 one tick lasts 1 ms. A 16-bit tick counter climbs toward a programmed timeout. When it gets there the count freezes and, if allowed, a single reset-request output pulses for a fixed number of cycles so that an external reset controller can restart the system.

Software configures the divisor and gates in a control word, sets the timeout, and kicks the watchdog by writing anything to a restart register. The live count can be read back next to the timeout at any time. Clearing the run bit pauses the count and setting it again continues from where it stopped.

Top module: `wdt_timer`

## Requirements
- R1: After the asynchronous reset, the control word and the timeout read as zero, the count is zero and rst_req_o is low.
- R2: Offset 0x0 is the control word. Bits 25 (divider gate), 24 (clock gate), 21 (reset allow), 18 (run) and 17:0 (divisor D) are stored and read back; every other bit reads zero.
- R3: Offset 0x8 holds the timeout T in bits 15:0 (read/write) and returns the live count in bits 31:16. Writes to bits 31:16 have no effect.
- R4: The count advances only while bits 25, 24 and 18 are all set. After the write that enables it, the count equals n once n*D rising edges have passed. A divisor of zero produces no ticks.
- R5: When the count reaches T it holds there. A timeout of zero never expires, and the count only ever steps up by one or returns to zero.
- R6: If bit 21 is set when the count reaches T, rst_req_o goes high at that same edge and stays high for exactly 16 cycles. If bit 21 is clear, rst_req_o stays low.
- R7: Any write to offset 0xC clears the count and the prescaler, so a full D*T period follows. Its data is ignored, it leaves the other registers unchanged, and 0xC reads zero.
- R8: Clearing bit 18 freezes the count and discards the partial tick. Setting it again continues from the frozen count, with the next tick D edges later.
- R9: Reads from any other offset return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte offset of the register |
| we_i | input | 1 | Write strobe, one write per cycle it is high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
Read data follows addr_i in the same cycle. A write takes effect at the rising edge where we_i is sampled. Counting from that edge, the count is n after n*D edges, and rst_req_o rises at edge T*D and falls at edge T*D+16. The bench drives and samples on falling clock edges and counts rising edges from each enabling or restart write. It compares the count field and rst_req_o on every cycle of the window against those formulas for several divisor and timeout pairs, and for stop, resume and restart. Register contents after writes that must have no effect are read back one cycle later.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DIV_W  = 18;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned CNT_SH = 16;
  localparam int unsigned PULSE_LEN = 16;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_TMO  = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_KICK = 4'hC;

  localparam int unsigned B_DIV_EN = 25;
  localparam int unsigned B_CLK_EN = 24;
  localparam int unsigned B_RST_EN = 21;
  localparam int unsigned B_RUN    = 18;

  localparam logic [REG_W-1:0] CTRL_MASK =
      (REG_W'(1) << B_DIV_EN) | (REG_W'(1) << B_CLK_EN) |
      (REG_W'(1) << B_RST_EN) | (REG_W'(1) << B_RUN) |
      ((REG_W'(1) << DIV_W) - REG_W'(1));
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic [DW-1:0]     div_o,
  output logic [CW-1:0]     tmo_o,
  output logic              kick_o
);
  logic [REG_W-1:0] ctrl_q;
  logic [CW-1:0]    tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      tmo_q  <= '0;
    end else if (we_i) begin
      if (addr_i == OFF_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (addr_i == OFF_TMO)  tmo_q  <= wdata_i[CW-1:0];
    end
  end

  assign kick_o   = we_i && (addr_i == OFF_KICK);
  assign run_o    = ctrl_q[B_DIV_EN] & ctrl_q[B_CLK_EN] & ctrl_q[B_RUN];
  assign rst_en_o = ctrl_q[B_RST_EN];
  assign div_o    = ctrl_q[DW-1:0];
  assign tmo_o    = tmo_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL: rdata_o = ctrl_q;
      OFF_TMO: begin
        rdata_o[CW-1:0]        = tmo_q;
        rdata_o[CNT_SH +: CW]  = cnt_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DW = 18
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  input  logic [DW-1:0] div_i,
  output logic          tick_o
);
  logic [DW-1:0] pre_q;
  logic          div_ok;
  logic          last;

  assign div_ok = div_i != '0;
  // >= keeps the wrap safe if the divisor shrinks mid-period
  assign last   = div_ok && (pre_q >= div_i - 1'b1);
  assign tick_o = run_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pre_q <= '0;
    else if (!run_i || clr_i)  pre_q <= '0;
    else if (last)             pre_q <= '0;
    else if (div_ok)           pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int unsigned CW        = 16,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] tmo_i,
  input  logic          rst_en_i,
  output logic [CW-1:0] cnt_o,
  output logic          rst_req_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic [PW-1:0] pls_q;
  logic          below;
  logic          fire;

  assign below   = cnt_q < tmo_i;
  assign cnt_inc = cnt_q + 1'b1;
  assign fire    = tick_i && !clr_i && below && (cnt_inc == tmo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (tick_i && below) cnt_q <= cnt_inc;
  end

  // one pulse per expiry; a new expiry during a pulse does not stretch it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pls_q <= '0;
    else if (fire && rst_en_i && pls_q == '0)   pls_q <= PW'(PULSE_LEN);
    else if (pls_q != '0)                       pls_q <= pls_q - 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = pls_q != '0;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned DW        = DIV_W,
  parameter int unsigned CW        = CNT_W,
  parameter int unsigned PULSE_CYC = PULSE_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rst_req_o
);
  logic          run_w;
  logic          rst_en_w;
  logic          kick_w;
  logic          tick_w;
  logic [DW-1:0] div_w;
  logic [CW-1:0] tmo_w;
  logic [CW-1:0] cnt_w;

  wdt_regs #(.DW(DW), .CW(CW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt_w),
    .rdata_o  (rdata_o),
    .run_o    (run_w),
    .rst_en_o (rst_en_w),
    .div_o    (div_w),
    .tmo_o    (tmo_w),
    .kick_o   (kick_w)
  );

  wdt_prescaler #(.DW(DW)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .clr_i  (kick_w),
    .div_i  (div_w),
    .tick_o (tick_w)
  );

  wdt_expiry #(.CW(CW), .PULSE_LEN(PULSE_CYC)) i_exp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .clr_i     (kick_w),
    .tmo_i     (tmo_w),
    .rst_en_i  (rst_en_w),
    .cnt_o     (cnt_w),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk
  import wdt_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned PULSE_CYC = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              run_i,
  input logic              rst_en_i,
  input logic [CW-1:0]     cnt_i,
  input logic [CW-1:0]     tmo_i,
  input logic              rst_req_i
);
  localparam int unsigned HW = $clog2(PULSE_CYC + 1) + 1;

  logic [HW-1:0] hi_q;
  logic          kick;
  logic          unmapped_wr;

  assign kick        = we_i && (addr_i == OFF_KICK);
  assign unmapped_wr = we_i && (addr_i != OFF_CTRL) && (addr_i != OFF_TMO) &&
                       (addr_i != OFF_KICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= '0;
    else if (rst_req_i) hi_q <= hi_q + 1'b1;
    else                hi_q <= '0;
  end

  assert_pulse_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_q <= HW'(PULSE_CYC));

  assert_pulse_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_i) |-> hi_q == HW'(PULSE_CYC));

  assert_rst_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_i) |-> $past(rst_en_i));

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != $past(cnt_i)) |-> (cnt_i == $past(cnt_i) + 1'b1 || cnt_i == '0));

  assert_count_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i >= tmo_i && !kick) |=> $stable(cnt_i));

  assert_kick_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> cnt_i == '0);

  assert_hold_stopped_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !kick) |=> $stable(cnt_i));

  assert_unmapped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_wr |=> ($stable(tmo_i) && $stable(run_i) && $stable(rst_en_i)));
endmodule

bind wdt_timer wdt_timer_chk #(.CW(CW), .PULSE_CYC(PULSE_CYC)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .run_i     (run_w),
  .rst_en_i  (rst_en_w),
  .cnt_i     (cnt_w),
  .tmo_i     (tmo_w),
  .rst_req_i (rst_req_o)
);

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN_ALL = 32'h0304_0000; // bits 25,24,18
  localparam logic [31:0] RST_EN = 32'h0020_0000; // bit 21

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_timer i_wdt_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .we_i      (we),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .rst_req_o (rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic clean();
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'h8, d); chk("R1 tmo/count", d, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    logic [31:0] d;
    wr(4'h8, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 ctrl readback", d, 32'h0327_FFFF);
    wr(4'h0, 32'h0);
  endtask

  task automatic t_tmo_field();
    logic [31:0] d;
    wr(4'h8, 32'hABCD_1234);
    rd(4'h8, d); chk("R3 upper read-only", d, 32'h0000_1234);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_expire(input int dv, input int tm, input bit ren, input string tag);
    logic [31:0] d;
    int ec, er;
    wr(4'h8, 32'(tm));
    wr(4'h0, EN_ALL | (ren ? RST_EN : 32'h0) | 32'(dv));
    for (int k = 1; k <= tm * dv + 20; k++) begin
      step();
      rd(4'h8, d);
      ec = (k / dv < tm) ? k / dv : tm;
      er = (ren && k >= tm * dv && k < tm * dv + 16) ? 1 : 0;
      chk({tag, " R4/R5 count"}, {16'h0, d[31:16]}, 32'(ec));
      chk({tag, " R6 rst_req"}, {31'h0, rst_req}, 32'(er));
    end
  endtask

  task automatic t_timeout_zero();
    logic [31:0] d;
    wr(4'h8, 32'h0);
    wr(4'h0, EN_ALL | RST_EN | 32'd1);
    for (int k = 0; k < 20; k++) step();
    rd(4'h8, d); chk("R5 zero timeout count", d, 32'h0);
    chk("R5 zero timeout rst_req", {31'h0, rst_req}, 32'h0);
    clean();
  endtask

  task automatic t_div_zero();
    logic [31:0] d;
    wr(4'h8, 32'd5);
    wr(4'h0, EN_ALL);
    for (int k = 0; k < 20; k++) step();
    rd(4'h8, d); chk("R4 zero divisor", d[31:16], 32'h0);
    clean();
  endtask

  task automatic t_gates();
    logic [31:0] d;
    wr(4'h8, 32'd5);
    wr(4'h0, 32'h0204_0001); // clock gate clear
    for (int k = 0; k < 12; k++) step();
    rd(4'h8, d); chk("R4 clock gate off", d[31:16], 32'h0);
    wr(4'h0, 32'h0104_0001); // divider gate clear
    for (int k = 0; k < 12; k++) step();
    rd(4'h8, d); chk("R4 divider gate off", d[31:16], 32'h0);
    wr(4'h0, 32'h0300_0001); // run clear
    for (int k = 0; k < 12; k++) step();
    rd(4'h8, d); chk("R4 run off", d[31:16], 32'h0);
    clean();
  endtask

  task automatic t_kick();
    logic [31:0] d;
    t_expire(3, 4, 1'b1, "R7 pre");
    wr(4'hC, 32'hDEAD_BEEF);
    rd(4'h8, d); chk("R7 count cleared", d, 32'h0000_0004);
    rd(4'h0, d); chk("R7 ctrl kept", d, EN_ALL | RST_EN | 32'd3);
    rd(4'hC, d); chk("R7 reads zero", d, 32'h0);
    for (int k = 1; k <= 14; k++) begin
      step();
      rd(4'h8, d);
      chk("R7 recount", {16'h0, d[31:16]}, 32'((k / 3 < 4) ? k / 3 : 4));
      chk("R7 rst_req", {31'h0, rst_req}, 32'((k >= 12) ? 1 : 0));
    end
    for (int k = 0; k < 20; k++) step();
    clean();
  endtask

  task automatic t_stop_resume();
    logic [31:0] d;
    wr(4'h8, 32'd100);
    wr(4'h0, EN_ALL | 32'd3);
    for (int k = 0; k < 7; k++) step();
    wr(4'h0, 32'h0300_0003); // run cleared
    rd(4'h8, d); chk("R8 frozen", d[31:16], 32'd2);
    for (int k = 0; k < 20; k++) step();
    rd(4'h8, d); chk("R8 still frozen", d[31:16], 32'd2);
    rd(4'h0, d); chk("R8 fields kept", d, 32'h0300_0003);
    wr(4'h0, EN_ALL | 32'd3);
    for (int k = 1; k <= 9; k++) begin
      step();
      rd(4'h8, d);
      chk("R8 resume", {16'h0, d[31:16]}, 32'(2 + k / 3));
    end
    clean();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(4'h8, 32'h0000_0077);
    wr(4'h0, 32'h0020_0005);
    rd(4'h4, d); chk("R9 read 0x4", d, 32'h0);
    rd(4'h1, d); chk("R9 read 0x1", d, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    wr(4'h9, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R9 ctrl unchanged", d, 32'h0020_0005);
    rd(4'h8, d); chk("R9 tmo unchanged", d, 32'h0000_0077);
    chk("R9 rst_req", {31'h0, rst_req}, 32'h0);
    clean();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_tmo_field();
    t_expire(3, 4, 1'b1, "R6 allowed");
    clean();
    t_expire(3, 4, 1'b0, "R6 blocked");
    clean();
    t_expire(1, 2, 1'b1, "R4 div1");
    clean();
    t_timeout_zero();
    t_div_zero();
    t_gates();
    t_kick();
    t_stop_resume();
    t_unmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule